// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block is the interrupt bookkeeping core of a 16550-style serial port. It watches events from the receiver (line errors), the receive FIFO (its fill count and pushes), the transmitter (holding register empty) and the four modem-control input pins. From these it keeps a set of pending interrupt sources, ranks them, and presents a registered identification byte, a registered modem-status byte, the interrupt-enable readback and a single interrupt request line.

The host side is reduced to strobes. There is a write strobe for the enable register, another for the FIFO control register, both sharing one data byte. There are read strobes for the identification, line-status, modem-status and receive-buffer registers, and a write strobe for the transmit holding register. The OUT2 bit of the modem control register arrives as a level and gates the request line. The receive FIFO is seen only through its fill count and a push pulse. The receive-buffer read strobe counts as a pop. The character timeout is timed in baud ticks, using the current frame length in bits.

Top module: `uart_irq_unit`

## Requirements
- R1: Pending enabled sources are ranked, and the low nibble of the identification byte reports the winner. The ranking from highest to lowest, with codes, is: line status 0110, receive data 0100, character timeout 1100, transmit empty 0010, modem status 0000. When no enabled source is pending, the nibble is 0001.
- R2: The receive-data source is active while the fill count is at least the trigger level. FCR bits 7:6 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. With FIFOs disabled, any nonzero count is enough. The source drops as soon as the count falls below the level.
- R3: In FIFO mode the character timeout becomes pending under these conditions: the count is nonzero, and no push and no receive-buffer read has happened for 4 x frame_bits baud ticks. A receive-buffer read clears it. It can only be reported when FCR bit 0 is 1.
- R4: A line_err pulse makes the line-status source pending. It stays pending until an LSR read.
- R5: A low-to-high change of tx_empty makes the transmit-empty source pending. It is cleared by a THR write. It is also cleared when an identification read begins while the identification byte shows code 0010.
- R6: While iir_rd is high, iir_q holds its value. Events arriving meanwhile are recorded, and they appear once the read ends.
- R7: Identification bits 7:6 are both 1 when FCR bit 0 is set, and both 0 otherwise. Bits 5:4 are always 0. A write to the enable register stores the data in bits 3:0 only. Bit 0 enables receive data and timeout, bit 1 enables transmit empty, bit 2 enables line status, and bit 3 enables modem status. Bits 7:4 of the readback are 0.
- R8: msr_q bits 4, 5, 6 and 7 are the complements of the registered cts_n, dsr_n, ri_n and dcd_n. Bits 0 to 3 set on a low-to-high change of the same pins, in the same order. An MSR read clears all four delta bits on the next cycle, except a bit whose pin rises in that same cycle. Any set delta bit makes the modem-status source pending.
- R9: irq is a registered output. It is 1 only when OUT2 is 1 and some enabled source is pending.
- R10: After reset, iir_q is 0x01, ier_q is 0x00, msr_q is 0x00 while all pins are high, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_we | input | 1 | Write strobe for the enable register |
| fcr_we | input | 1 | Write strobe for the FIFO control register |
| wdata | input | 8 | Write data for both register writes |
| out2 | input | 1 | OUT2 level from the modem control register |
| iir_rd | input | 1 | Identification register read in progress |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe (FIFO pop) |
| thr_wr | input | 1 | Transmit holding register write strobe |
| line_err | input | 1 | Receiver line error event pulse |
| tx_empty | input | 1 | Transmit holding register empty level |
| rx_push | input | 1 | Byte entered the receive FIFO |
| rx_count | input | CNT_W | Receive FIFO fill count |
| baud_tick | input | 1 | One bit time has elapsed |
| frame_bits | input | FRAME_W | Bits per character frame |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| ier_q | output | 8 | Enable register readback |
| iir_q | output | 8 | Identification byte |
| msr_q | output | 8 | Modem status byte |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pending flag shows up in iir_q one clock after the event that should have set or cleared it, and in irq in the same cycle. A slip in the ranking also shows there, as the wrong code whenever two sources overlap. A wrong timeout counter shows up as the 1100 code appearing one tick early or late. A wrong delta or pin register shows up directly in msr_q on the cycle after the pin change or the MSR read. The bench steps a behavioural model in lockstep, so any such divergence is reported on the first cycle it reaches a port.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_LINE = 4'b0110,
    ID_RXD  = 4'b0100,
    ID_TOUT = 4'b1100,
    ID_TXE  = 4'b0010,
    ID_MDM  = 4'b0000,
    ID_IDLE = 4'b0001
  } iid_e;

  // Receive trigger level in bytes for a two-bit selector
  function automatic int unsigned trig_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_msr.sv
module uart_irq_msr #(
  parameter int LINES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LINES-1:0]   pins_n,
  input  logic               msr_rd,
  output logic [2*LINES-1:0] msr,
  output logic               ms_pend
);

  logic [LINES-1:0] pin_q;
  logic [LINES-1:0] delta;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_q[i] <= 1'b1;
        delta[i] <= 1'b0;
      end else begin
        pin_q[i] <= pins_n[i];
        delta[i] <= (pins_n[i] & ~pin_q[i]) | (delta[i] & ~msr_rd);
      end
    end
  end

  assign msr     = {~pin_q, delta};
  assign ms_pend = |delta;

endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int CNT_W    = 5,
  parameter int FRAME_W  = 4,
  parameter int TO_CHARS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_en,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic               rx_push,
  input  logic               rx_pop,
  input  logic               baud_tick,
  input  logic [FRAME_W-1:0] frame_bits,
  output logic               to_pend
);

  localparam int LIM_W = FRAME_W + $clog2(TO_CHARS) + 1;

  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] tcnt;
  logic             idle_reset;

  assign limit      = LIM_W'(TO_CHARS) * LIM_W'(frame_bits);
  assign idle_reset = rx_push | rx_pop | (rx_count == '0) | ~fifo_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt    <= '0;
      to_pend <= 1'b0;
    end else begin
      if (idle_reset)
        tcnt <= '0;
      else if (baud_tick && tcnt < limit)
        tcnt <= tcnt + 1'b1;

      if (rx_pop)
        to_pend <= 1'b0;
      else if (fifo_en && rx_count != '0 && tcnt >= limit)
        to_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [3:0] ena,
  input  logic       fifo_en,
  input  logic       ls,
  input  logic       rda,
  input  logic       to,
  input  logic       thre,
  input  logic       ms,
  output iid_e       code,
  output logic       active
);

  always_comb begin
    if (ena[2] && ls)
      code = ID_LINE;
    else if (ena[0] && rda)
      code = ID_RXD;
    else if (ena[0] && to && fifo_en)
      code = ID_TOUT;
    else if (ena[1] && thre)
      code = ID_TXE;
    else if (ena[3] && ms)
      code = ID_MDM;
    else
      code = ID_IDLE;
    active = (code != ID_IDLE);
  end

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int FRAME_W  = 4,
  parameter int TO_CHARS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ier_we,
  input  logic               fcr_we,
  input  logic [7:0]         wdata,
  input  logic               out2,
  input  logic               iir_rd,
  input  logic               lsr_rd,
  input  logic               msr_rd,
  input  logic               rbr_rd,
  input  logic               thr_wr,
  input  logic               line_err,
  input  logic               tx_empty,
  input  logic               rx_push,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic               baud_tick,
  input  logic [FRAME_W-1:0] frame_bits,
  input  logic               cts_n,
  input  logic               dsr_n,
  input  logic               ri_n,
  input  logic               dcd_n,
  output logic [7:0]         ier_q,
  output logic [7:0]         iir_q,
  output logic [7:0]         msr_q,
  output logic               irq
);

  logic [3:0] ier;
  logic       fifo_en;
  logic [1:0] trig;
  logic       ls_pend, thre_pend, tx_empty_q, iir_rd_q;
  logic       to_pend, ms_pend, rda_lvl, active;
  iid_e       code;
  logic [CNT_W-1:0] trig_lvl;

  assign trig_lvl = CNT_W'(trig_bytes(trig));
  assign rda_lvl  = fifo_en ? (rx_count >= trig_lvl) : (rx_count != '0);
  assign ier_q    = {4'b0000, ier};

  uart_irq_msr #(.LINES(4)) u_msr (
    .clk     (clk),
    .rst     (rst),
    .pins_n  ({dcd_n, ri_n, dsr_n, cts_n}),
    .msr_rd  (msr_rd),
    .msr     (msr_q),
    .ms_pend (ms_pend)
  );

  uart_irq_timeout #(.CNT_W(CNT_W), .FRAME_W(FRAME_W), .TO_CHARS(TO_CHARS)) u_to (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .rx_count   (rx_count),
    .rx_push    (rx_push),
    .rx_pop     (rbr_rd),
    .baud_tick  (baud_tick),
    .frame_bits (frame_bits),
    .to_pend    (to_pend)
  );

  uart_irq_prio u_prio (
    .ena     (ier),
    .fifo_en (fifo_en),
    .ls      (ls_pend),
    .rda     (rda_lvl),
    .to      (to_pend),
    .thre    (thre_pend),
    .ms      (ms_pend),
    .code    (code),
    .active  (active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ier        <= '0;
      fifo_en    <= 1'b0;
      trig       <= 2'b00;
      ls_pend    <= 1'b0;
      thre_pend  <= 1'b0;
      tx_empty_q <= 1'b0;
      iir_rd_q   <= 1'b0;
      iir_q      <= {4'b0000, ID_IDLE};
      irq        <= 1'b0;
    end else begin
      if (ier_we)
        ier <= wdata[3:0];
      if (fcr_we) begin
        fifo_en <= wdata[0];
        trig    <= wdata[7:6];
      end
      ls_pend    <= line_err | (ls_pend & ~lsr_rd);
      tx_empty_q <= tx_empty;
      iir_rd_q   <= iir_rd;
      if (thr_wr)
        thre_pend <= 1'b0;
      else if (tx_empty && !tx_empty_q)
        thre_pend <= 1'b1;
      else if (iir_rd && !iir_rd_q && iir_q[3:0] == ID_TXE)
        thre_pend <= 1'b0;
      if (!iir_rd)
        iir_q <= {{2{fifo_en}}, 2'b00, code};
      irq <= out2 & active;
    end
  end

endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       out2,
  input logic       iir_rd,
  input logic       msr_rd,
  input logic       line_err,
  input logic       cts_n,
  input logic       dsr_n,
  input logic       ri_n,
  input logic       dcd_n,
  input logic [7:0] ier_q,
  input logic [7:0] iir_q,
  input logic [7:0] msr_q,
  input logic       irq
);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !out2 |=> !irq);

  assert_fixed_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (iir_q[5:4] == 2'b00) && (ier_q[7:4] == 4'b0000));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    iir_rd |=> $stable(iir_q));

  assert_tout_fifo_R3: assert property (@(posedge clk) disable iff (rst)
    (iir_q[3:0] == 4'b1100) |-> (iir_q[7:6] == 2'b11));

  assert_line_top_R1: assert property (@(posedge clk) disable iff (rst)
    $past(line_err) && ier_q[2] && !iir_rd |=> (iir_q[3:0] == 4'b0110));

  assert_delta_clear_R8: assert property (@(posedge clk) disable iff (rst)
    msr_rd && $stable({dcd_n, ri_n, dsr_n, cts_n}) |=> (msr_q[3:0] == 4'b0000));

endmodule

bind uart_irq_unit uart_irq_unit_chk u_chk (.*);

// File: tb/uart_irq_unit_tb.sv
module uart_irq_unit_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ier_we = 0, fcr_we = 0, out2 = 0, iir_rd = 0, lsr_rd = 0, msr_rd = 0;
  logic       rbr_rd = 0, thr_wr = 0, line_err = 0, tx_empty = 0, rx_push = 0, baud_tick = 0;
  logic [7:0] wdata = 0;
  logic [4:0] rx_count = 0;
  logic [3:0] frame_bits = 4'd10;
  logic       cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic [7:0] ier_q, iir_q, msr_q;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  uart_irq_unit u_dut (.*);

  // Behavioural reference model
  int m_ier, m_fifo, m_trig, m_ls, m_thre, m_txq, m_rdq, m_iir, m_irq, m_tcnt, m_to;
  int m_pin[4];
  int m_dlt[4];

  function automatic int trig_of(int s);
    if (s == 0) return 1;
    if (s == 1) return 4;
    if (s == 2) return 8;
    return 14;
  endfunction

  function automatic int model_code();
    int rda;
    int msp;
    rda = m_fifo ? (rx_count >= trig_of(m_trig)) : (rx_count != 0);
    msp = m_dlt[0] | m_dlt[1] | m_dlt[2] | m_dlt[3];
    if ((m_ier & 4) && m_ls) return 6;
    if ((m_ier & 1) && rda) return 4;
    if ((m_ier & 1) && m_to && m_fifo) return 12;
    if ((m_ier & 2) && m_thre) return 2;
    if ((m_ier & 8) && msp) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    int c;
    int lim;
    int pins[4];
    pins[0] = cts_n; pins[1] = dsr_n; pins[2] = ri_n; pins[3] = dcd_n;
    if (rst) begin
      m_ier = 0; m_fifo = 0; m_trig = 0; m_ls = 0; m_thre = 0; m_txq = 0; m_rdq = 0;
      m_iir = 1; m_irq = 0; m_tcnt = 0; m_to = 0;
      for (int i = 0; i < 4; i++) begin m_pin[i] = 1; m_dlt[i] = 0; end
    end else begin
      c = model_code();
      if (!iir_rd) m_iir = (m_fifo ? 8'hC0 : 0) | c;
      m_irq = out2 && (c != 1);
      if (thr_wr) m_thre = 0;
      else if (tx_empty && !m_txq) m_thre = 1;
      else if (iir_rd && !m_rdq && (m_iir_prev & 15) == 2) m_thre = 0;
      m_txq = tx_empty; m_rdq = iir_rd;
      m_ls = line_err || (m_ls && !lsr_rd);
      lim = 4 * frame_bits;
      if (rbr_rd) m_to = 0;
      else if (m_fifo && rx_count != 0 && m_tcnt >= lim) m_to = 1;
      if (rx_push || rbr_rd || rx_count == 0 || !m_fifo) m_tcnt = 0;
      else if (baud_tick && m_tcnt < lim) m_tcnt++;
      for (int i = 0; i < 4; i++) begin
        m_dlt[i] = (pins[i] && !m_pin[i]) || (m_dlt[i] && !msr_rd);
        m_pin[i] = pins[i];
      end
      if (ier_we) m_ier = wdata & 15;
      if (fcr_we) begin m_fifo = wdata[0]; m_trig = wdata[7:6]; end
    end
    m_iir_prev = m_iir;
  end

  int m_iir_prev = 1;

  function automatic int model_msr();
    int v;
    v = 0;
    for (int i = 0; i < 4; i++) begin
      if (!m_pin[i]) v |= (1 << (4 + i));
      if (m_dlt[i]) v |= (1 << i);
    end
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Lockstep comparison on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R1 iir vs model", int'(iir_q), m_iir);
      chk("R8 msr vs model", int'(msr_q), model_msr());
      chk("R9 irq vs model", int'(irq), m_irq);
      chk("R7 ier vs model", int'(ier_q), m_ier);
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  initial begin
    idle(4);
    chk("R10 iir reset", int'(iir_q), 8'h01);
    chk("R10 ier reset", int'(ier_q), 8'h00);
    chk("R10 msr reset", int'(msr_q), 8'h00);
    chk("R10 irq reset", int'(irq), 0);
    @(negedge clk); rst = 1'b0;
    idle(2);
    chk("R10 iir after release", int'(iir_q), 8'h01);

    // R7 enables
    @(negedge clk); wdata = 8'hFF; ier_we = 1;
    @(negedge clk); ier_we = 0; out2 = 1;
    idle(2);
    chk("R7 ier upper zero", int'(ier_q), 8'h0F);

    // R5 transmit empty: set on rise, clear on identification read
    @(negedge clk); tx_empty = 1;
    idle(3);
    chk("R5 thre code", int'(iir_q), 8'h02);
    chk("R9 irq with out2", int'(irq), 1);
    pulse(iir_rd);
    idle(3);
    chk("R5 thre cleared by id read", int'(iir_q), 8'h01);

    // R7 FIFO mode bits, trigger 14
    @(negedge clk); wdata = 8'hC1; fcr_we = 1;
    @(negedge clk); fcr_we = 0; rx_count = 1; rx_push = 1;
    @(negedge clk); rx_push = 0;
    idle(3);
    chk("R7 fifo bits", int'(iir_q), 8'hC1);

    // R4 line status, R1 priority over receive data
    @(negedge clk); rx_count = 14;
    idle(3);
    chk("R2 trigger 14 reached", int'(iir_q), 8'hC4);
    pulse(line_err);
    idle(3);
    chk("R1 line status outranks data", int'(iir_q), 8'hC6);
    pulse(lsr_rd);
    idle(3);
    chk("R4 cleared by LSR read", int'(iir_q), 8'hC4);
    @(negedge clk); rx_count = 13;
    idle(3);
    chk("R2 below trigger 14", int'(iir_q), 8'hC1);

    // R2 other trigger levels
    @(negedge clk); wdata = 8'h01; fcr_we = 1;
    @(negedge clk); fcr_we = 0;
    idle(3);
    chk("R2 trigger 1", int'(iir_q), 8'hC4);
    @(negedge clk); wdata = 8'h41; fcr_we = 1; rx_count = 3;
    @(negedge clk); fcr_we = 0;
    idle(3);
    chk("R2 trigger 4 not met", int'(iir_q), 8'hC1);
    @(negedge clk); rx_count = 4;
    idle(3);
    chk("R2 trigger 4 met", int'(iir_q), 8'hC4);
    @(negedge clk); wdata = 8'h81; fcr_we = 1;
    @(negedge clk); fcr_we = 0;
    idle(3);
    chk("R2 trigger 8 not met", int'(iir_q), 8'hC1);

    // R3 character timeout
    @(negedge clk); wdata = 8'hC1; fcr_we = 1; rx_count = 1; rx_push = 1; frame_bits = 2;
    @(negedge clk); fcr_we = 0; rx_push = 0; baud_tick = 1;
    idle(6);
    chk("R3 no timeout yet", int'(iir_q), 8'hC1);
    idle(8);
    chk("R3 timeout raised", int'(iir_q), 8'hCC);
    @(negedge clk); baud_tick = 0; rbr_rd = 1; rx_count = 0;
    @(negedge clk); rbr_rd = 0;
    idle(3);
    chk("R3 timeout cleared by read", int'(iir_q), 8'hC1);
    frame_bits = 10;

    // R5 clear by THR write
    @(negedge clk); tx_empty = 0;
    @(negedge clk); tx_empty = 1;
    idle(3);
    chk("R5 thre again", int'(iir_q), 8'hC2);
    pulse(thr_wr);
    idle(3);
    chk("R5 cleared by THR write", int'(iir_q), 8'hC1);

    // R6 freeze during identification read
    @(negedge clk); iir_rd = 1;
    @(negedge clk); line_err = 1;
    @(negedge clk); line_err = 0;
    idle(2);
    chk("R6 frozen while read", int'(iir_q), 8'hC1);
    chk("R9 irq live during read", int'(irq), 1);
    @(negedge clk); iir_rd = 0;
    idle(3);
    chk("R6 event shows after read", int'(iir_q), 8'hC6);
    pulse(lsr_rd);
    idle(3);

    // R8 modem status
    @(negedge clk); cts_n = 0;
    idle(3);
    chk("R8 falling pin no delta", int'(msr_q), 8'h10);
    @(negedge clk); cts_n = 1;
    idle(3);
    chk("R8 rising pin delta", int'(msr_q), 8'h01);
    chk("R1 modem code", int'(iir_q), 8'hC0);
    @(negedge clk); out2 = 0;
    idle(3);
    chk("R9 gated by out2", int'(irq), 0);
    @(negedge clk); out2 = 1;
    pulse(msr_rd);
    idle(3);
    chk("R8 cleared by read", int'(msr_q), 8'h00);
    @(negedge clk); ri_n = 0; dcd_n = 0;
    @(negedge clk); ri_n = 1;
    idle(3);
    chk("R8 ri delta and dcd level", int'(msr_q), 8'h84);
    @(negedge clk); msr_rd = 1; dcd_n = 1;
    @(negedge clk); msr_rd = 0;
    idle(3);
    chk("R8 edge during read kept", int'(msr_q), 8'h08);

    // R7 enables off mask pending delta
    @(negedge clk); wdata = 8'h00; ier_we = 1;
    @(negedge clk); ier_we = 0;
    idle(3);
    chk("R7 masked sources", int'(iir_q), 8'hC1);
    chk("R9 no irq when masked", int'(irq), 0);

    // FIFO off
    @(negedge clk); wdata = 8'h00; fcr_we = 1;
    @(negedge clk); fcr_we = 0;
    idle(3);
    chk("R7 fifo bits clear", int'(iir_q), 8'h01);

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule